// File: doc/BRIEF.md
# Modular exponentiation engine

This block raises a message value to an exponent modulo a modulus (result = m^e mod n) for unsigned operands of a configurable width. It is the arithmetic core of a public-key encrypt or decrypt step. A controller presents the message, the exponent, the modulus and an address tag, pulses `start`, and later collects the result together with the same tag. Because the tag travels with the job, several engines can be fed round-robin and their results can be written back out of order.

The exponent is scanned left to right. Zero bits above the leading one are skipped, and the accumulator is seeded with the message reduced modulo n. Each remaining bit costs a modular square, and each remaining one bit costs a further modular multiply by the reduced message. All modular products come from one bit-serial interleaved shift/add/subtract unit. The unit never lets its partial value reach n, so no wide multiplier or divider is needed.

Top module: `modexp_engine`

## Requirements
- R1: With n > 1 and a nonzero exponent, the result presented with `finished_o` equals m^e mod n.
- R2: An exponent of 0 yields 1 mod n. `finished_o` rises right after the accepting clock edge, and `busy_o` is not raised for such a job.
- R3: A modulus of 1 yields a result of 0 for every message and exponent.
- R4: A message value equal to or above n is reduced before use, so the result equals (m mod n)^e mod n.
- R5: For a nonzero exponent whose highest set bit is at index k and which has p set bits, `finished_o` rises exactly (WIDTH+2)*(k+p) clock edges after the accepting edge.
- R6: `finished_o` is high for a single cycle per job. Every result held in `result_o` is below n.
- R7: `tag_o` shows the tag sampled with the accepted start, and is valid while `finished_o` is high.
- R8: `busy_o` is high from the cycle after an accepted start (nonzero exponent) until the finishing cycle, in which it is already low.
- R9: A `start` raised while `busy_o` is high is ignored. The running job's result and tag are unaffected, and no extra `finished_o` pulse follows.
- R10: After reset `busy_o`, `finished_o`, `result_o` and `tag_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a job with the operands presented this cycle |
| msg_i | input | WIDTH | Message value m |
| exp_i | input | WIDTH | Exponent e |
| mod_i | input | WIDTH | Modulus n (must be at least 1) |
| tag_i | input | TAGW | Address tag for this job |
| result_o | output | WIDTH | m^e mod n, valid with finished_o |
| tag_o | output | TAGW | Tag of the job that produced result_o |
| finished_o | output | 1 | One-cycle pulse: result is valid |
| busy_o | output | 1 | A job is running and start is ignored |

## Verification
Each result is due a fixed number of edges after its start: (WIDTH+2) edges per modular product, one product for the reduction, one per remaining exponent bit and one per remaining set bit. A zero exponent finishes right after the accepting edge. The bench drives and samples on falling edges. It counts falling edges from the one after the accepting edge until `finished_o` appears, and compares that count with the arithmetic formula. It reads the result and tag in that same cycle and checks one cycle later that the pulse has dropped. The test that drops a start arriving mid-job then waits three product times more to prove no second pulse comes.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_REDUCE = 2'd1,
        PH_SQUARE = 2'd2,
        PH_MULT   = 2'd3
    } phase_t;

endpackage

// File: rtl/modexp_lead_one.sv
module modexp_lead_one #(
    parameter int WIDTH = 32,
    parameter int IDXW  = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [IDXW-1:0]  idx_o
);

    // Highest set bit position; 0 when the vector is empty.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (vec_i[i]) begin
                idx_o = IDXW'(i);
            end
        end
    end

endmodule

// File: rtl/modexp_mulred.sv
module modexp_mulred #(
    parameter int WIDTH = 32,
    parameter int IDXW  = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] n_i,
    output logic [WIDTH-1:0] prod_o,
    output logic             done_o
);

    typedef struct packed {
        logic [WIDTH-1:0] p;
        logic [WIDTH-1:0] a;
        logic [WIDTH-1:0] b;
        logic [WIDTH-1:0] n;
        logic [IDXW-1:0]  cnt;
        logic             busy;
        logic             done;
    } mr_regs_t;

    mr_regs_t r_q, r_d;

    logic [WIDTH:0] dbl, dbl_red, acc, acc_red, n_ext, b_ext;

    // One interleaved step: double, fold back, add the selected addend, fold back.
    always_comb begin
        n_ext   = {1'b0, r_q.n};
        b_ext   = {1'b0, r_q.b};
        dbl     = {r_q.p, 1'b0};
        dbl_red = (dbl >= n_ext) ? dbl - n_ext : dbl;
        acc     = dbl_red + (r_q.a[WIDTH-1] ? b_ext : '0);
        acc_red = (acc >= n_ext) ? acc - n_ext : acc;
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (go_i) begin
            r_d.p    = '0;
            r_d.a    = a_i;
            r_d.b    = b_i;
            r_d.n    = n_i;
            r_d.cnt  = IDXW'(WIDTH - 1);
            r_d.busy = 1'b1;
        end else if (r_q.busy) begin
            r_d.p   = acc_red[WIDTH-1:0];
            r_d.a   = {r_q.a[WIDTH-2:0], 1'b0};
            r_d.cnt = r_q.cnt - 1'b1;
            if (r_q.cnt == '0) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign prod_o = r_q.p;
    assign done_o = r_q.done;

    // R6: the running partial value never reaches the modulus
    a_r6_partial_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.busy && r_q.n != '0) |-> (r_q.p < r_q.n));

    // R6: a product completion is a single-cycle event
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/modexp_engine.sv
module modexp_engine #(
    parameter int WIDTH = 32,
    parameter int TAGW  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] msg_i,
    input  logic [WIDTH-1:0] exp_i,
    input  logic [WIDTH-1:0] mod_i,
    input  logic [TAGW-1:0]  tag_i,
    output logic [WIDTH-1:0] result_o,
    output logic [TAGW-1:0]  tag_o,
    output logic             finished_o,
    output logic             busy_o
);

    import modexp_pkg::*;

    localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    typedef struct packed {
        phase_t           phase;
        logic [WIDTH-1:0] e;
        logic [WIDTH-1:0] n;
        logic [WIDTH-1:0] mr;
        logic [IDXW-1:0]  idx;
        logic             go;
        logic [WIDTH-1:0] op_a;
        logic [WIDTH-1:0] op_b;
        logic             busy;
        logic             fin;
        logic [WIDTH-1:0] res;
        logic [TAGW-1:0]  tag;
    } eng_regs_t;

    eng_regs_t r_q, r_d;

    logic [IDXW-1:0]  lead_idx;
    logic [WIDTH-1:0] prod;
    logic             prod_done;
    logic [WIDTH-1:0] one_mod;

    modexp_lead_one #(.WIDTH(WIDTH), .IDXW(IDXW)) u_lead (
        .vec_i (exp_i),
        .idx_o (lead_idx)
    );

    modexp_mulred #(.WIDTH(WIDTH), .IDXW(IDXW)) u_mulred (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (r_q.go),
        .a_i    (r_q.op_a),
        .b_i    (r_q.op_b),
        .n_i    (r_q.n),
        .prod_o (prod),
        .done_o (prod_done)
    );

    // 1 mod n for the modulus presented at the port
    assign one_mod = (mod_i == WIDTH'(1)) ? '0 : WIDTH'(1);

    always_comb begin
        r_d     = r_q;
        r_d.go  = 1'b0;
        r_d.fin = 1'b0;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (start) begin
                    r_d.e   = exp_i;
                    r_d.n   = mod_i;
                    r_d.tag = tag_i;
                    if (exp_i == '0) begin
                        r_d.res = one_mod;
                        r_d.fin = 1'b1;
                    end else begin
                        r_d.idx   = lead_idx;
                        r_d.op_a  = msg_i;
                        r_d.op_b  = one_mod;
                        r_d.go    = 1'b1;
                        r_d.busy  = 1'b1;
                        r_d.phase = PH_REDUCE;
                    end
                end
            end
            PH_REDUCE, PH_MULT: begin
                if (prod_done) begin
                    if (r_q.phase == PH_REDUCE) begin
                        r_d.mr = prod;
                    end
                    if (r_q.idx == '0) begin
                        r_d.res   = prod;
                        r_d.fin   = 1'b1;
                        r_d.busy  = 1'b0;
                        r_d.phase = PH_IDLE;
                    end else begin
                        r_d.op_a  = prod;
                        r_d.op_b  = prod;
                        r_d.go    = 1'b1;
                        r_d.idx   = r_q.idx - 1'b1;
                        r_d.phase = PH_SQUARE;
                    end
                end
            end
            PH_SQUARE: begin
                if (prod_done) begin
                    if (r_q.e[r_q.idx]) begin
                        r_d.op_a  = prod;
                        r_d.op_b  = r_q.mr;
                        r_d.go    = 1'b1;
                        r_d.phase = PH_MULT;
                    end else if (r_q.idx == '0) begin
                        r_d.res   = prod;
                        r_d.fin   = 1'b1;
                        r_d.busy  = 1'b0;
                        r_d.phase = PH_IDLE;
                    end else begin
                        r_d.op_a  = prod;
                        r_d.op_b  = prod;
                        r_d.go    = 1'b1;
                        r_d.idx   = r_q.idx - 1'b1;
                    end
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign result_o   = r_q.res;
    assign tag_o      = r_q.tag;
    assign finished_o = r_q.fin;
    assign busy_o     = r_q.busy;

    // R6: a finished result is already reduced below the modulus
    a_r6_result_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (finished_o && r_q.n != '0) |-> (result_o < r_q.n));

    // R8: busy is already low in the finishing cycle
    a_r8_finish_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        finished_o |-> !busy_o);

    // R8: busy only rises after a start was presented
    a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start));

    // R9: a start during a job leaves the job's tag untouched
    a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start) |=> $stable(tag_o));

endmodule

// File: tb/modexp_engine_bench.sv
module modexp_engine_bench;

    localparam int W    = 8;
    localparam int TW   = 4;
    localparam int STEP = W + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  msg = '0, ex = '0, md = '0;
    logic [TW-1:0] tag = '0;
    logic [W-1:0]  result;
    logic [TW-1:0] tag_out;
    logic          finished, busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    modexp_engine #(.WIDTH(W), .TAGW(TW)) u_modexp_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .msg_i      (msg),
        .exp_i      (ex),
        .mod_i      (md),
        .tag_i      (tag),
        .result_o   (result),
        .tag_o      (tag_out),
        .finished_o (finished),
        .busy_o     (busy)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint ref_pow(longint m, longint e, longint n);
        longint r = 1 % n;
        longint b = m % n;
        for (int i = W - 1; i >= 0; i--) begin
            r = (r * r) % n;
            if (e[i]) r = (r * b) % n;
        end
        return r;
    endfunction

    function automatic int ref_lat(int e);
        int top = 0;
        int pc  = 0;
        if (e == 0) return 0;
        for (int i = 0; i < W; i++) begin
            if (e[i]) begin
                top = i;
                pc++;
            end
        end
        return STEP * (top + pc);
    endfunction

    // Launch a job and wait for its result; optionally inject a start mid-job.
    task automatic run_job(input int m, input int e, input int n, input int t, input bit inject);
        int lat = 0;
        longint want = ref_pow(m, e, n);
        string rq = (n == 1) ? "R3" : (e == 0) ? "R2" : (m >= n) ? "R4" : "R1";
        @(negedge clk);
        msg = W'(m); ex = W'(e); md = W'(n); tag = TW'(t); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == (e != 0), "R8 busy after start", busy, e != 0);
        while (!finished && lat < 4000) begin
            if (inject && lat == 5) begin
                msg = 8'd9; ex = 8'd1; md = 8'd7; tag = TW'(t + 5); start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check(lat == ref_lat(e), "R5 latency", lat, ref_lat(e));
        check(longint'(result) == want, inject ? "R9 result" : rq, result, want);
        check(int'(tag_out) == (t % (1 << TW)), inject ? "R9 tag" : "R7 tag", tag_out, t % (1 << TW));
        check(!busy, "R8 busy low at finish", busy, 0);
        @(negedge clk);
        check(!finished, "R6 single pulse", finished, 0);
        if (inject) begin
            int extra = 0;
            for (int k = 0; k < 3 * STEP; k++) begin
                @(negedge clk);
                if (finished) extra++;
            end
            check(extra == 0, "R9 no extra finish", extra, 0);
        end
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin : stim
        int nlist [8] = '{2, 3, 7, 13, 128, 251, 255, 1};
        int elist [8] = '{0, 1, 2, 3, 149, 255, 128, 254};
        repeat (3) @(negedge clk);
        // R10: reset state
        check(busy == 0, "R10 busy", busy, 0);
        check(finished == 0, "R10 finished", finished, 0);
        check(result == 0, "R10 result", result, 0);
        check(tag_out == 0, "R10 tag", tag_out, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int ni = 0; ni < 8; ni++) begin
            for (int m = 0; m < 256; m += 37) begin
                for (int ei = 0; ei < 8; ei++) begin
                    run_job(m, elist[ei], nlist[ni], (m + ei) % 16, 1'b0);
                end
            end
        end
        // worked example: exponent 149 over a prime modulus
        run_job(5, 149, 251, 3, 1'b0);
        // R9: start while busy is ignored
        run_job(5, 149, 251, 3, 1'b1);
        // R2: zero exponent right after another job
        run_job(200, 0, 1, 6, 1'b0);
        run_job(200, 0, 97, 7, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule